// File: doc/BRIEF.md
# Register and Scratch-RAM Command Sequencer

This block sits behind a two-wire serial slave and turns the first byte of each transfer, an address/command byte, into a sequence of single-cycle access strobes. It serves two targets. One is a bank of eight clock registers: seven timekeeping registers plus a control register. The other is a 96-byte scratch RAM. The command byte picks the target, whether the transfer is a single access or a burst, and the starting location. Its least significant bit gives the direction: 0 for write, 1 for read.

The serial shifter reports events as one-cycle strobes: a new command, a received data byte, a request for the next read byte, and the stop condition. The block answers each event with a registered strobe that carries the resolved RAM location or register index.

RAM writes are committed one byte at a time. A clock-register burst write is staged inside the block and released as one eight-byte load at the stop condition. The release happens only when all eight bytes arrived and the transfer was not write-protected. The live write-protect level comes from bit 7 of the control register, which is held outside this block.

Top module: `rtc_cmd_seq`

## Requirements
- R1: Even commands 3Eh..FCh write one byte and odd commands 3Fh..FDh read one byte at RAM location (command − 3Eh) >> 1, giving locations 0..95. Only the first data byte or read request after such a command produces a strobe.
- R2: Command FEh starts a RAM burst write and FFh a RAM burst read. Both begin at location 0 and advance by one after each byte.
- R3: In a RAM burst write every received byte produces its own `ram_we` strobe at once. A burst stopped early keeps the bytes already written.
- R4: A RAM burst read strobes `ram_re` for locations 0..95 in order. Read requests after location 95 produce no strobe.
- R5: The RAM burst location does not wrap: a 97th written byte produces no `ram_we`.
- R6: While `ctl_wp` is 1 when a data byte arrives, that byte produces no `ram_we` (single or burst).
- R7: Command 02h+2k writes and 03h+2k reads clock register k, for k = 0..7, where k = 7 is the control register. While `ctl_wp` is 1, writes to k = 0..6 produce no `reg_we`, and writes to k = 7 still do.
- R8: Command 01h strobes `reg_re` for indexes 0..7 on successive read requests, and nothing after that. Command 00h stages bytes; the stop that ends it pulses `burst_load` with byte k in `burst_data[8k+7:8k]`.
- R9: A clock burst write produces no `burst_load` when fewer than eight bytes arrived. It also produces none when `ctl_wp` was 1 in the command cycle, even if `ctl_wp` is cleared later.
- R10: Commands 12h..3Dh are ignored: no strobe follows their data bytes or read requests.
- R11: Every output strobe appears in the cycle after its input strobe, and at most one output strobe is high per cycle. A data byte and a stop in the same cycle are handled byte first. Data and read strobes in the same cycle as `cmd_valid` are ignored.
- R12: After reset all output strobes are low and no transfer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte received (start of transfer) |
| cmd_byte | input | 8 | Address/command byte |
| byte_valid | input | 1 | Data byte received |
| byte_data | input | 8 | Received data byte |
| rd_req | input | 1 | Master requests the next read byte |
| stop | input | 1 | Stop condition seen |
| ctl_wp | input | 1 | Write-protect bit from the control register |
| ram_addr | output | 7 | RAM location of the current strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| reg_idx | output | 3 | Clock register index of the current strobe |
| reg_wdata | output | 8 | Single register write data |
| reg_we | output | 1 | Single register write strobe |
| reg_re | output | 1 | Register read strobe |
| burst_load | output | 1 | Load all eight clock registers at once |
| burst_data | output | 64 | Staged clock burst bytes, index 0 in the low byte |

## Verification
The eighth byte of a clock burst write and the stop condition can arrive in the same cycle. The bench provokes this by raising `byte_valid` and `stop` together on the final byte. It then expects a `burst_load` in the next cycle that carries all eight bytes, with the last one in the top byte lane. A second case raises a data byte together with a new command. Here the bench expects no write strobe, and expects the following byte to be handled under the new command.

// File: rtl/rtc_cmd_pkg.sv
package rtc_cmd_pkg;

  typedef enum logic [2:0] {
    MD_NONE,
    MD_RAM_ONE,
    MD_RAM_BURST,
    MD_REG_ONE,
    MD_CLK_BURST
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic       rd;
    logic [7:0] start;
  } cmd_t;

  // Command space: 00/01 clock burst, then one even/odd pair per clock
  // register, then one pair per RAM byte from ram_base, then the RAM burst pair.
  function automatic cmd_t decode_cmd(input logic [7:0] c,
                                      input logic [7:0] ram_base,
                                      input int unsigned ram_depth,
                                      input int unsigned nreg);
    cmd_t d;
    int unsigned cv, rb, ram_end;
    cv      = 32'(c);
    rb      = 32'(ram_base);
    ram_end = rb + 2 * ram_depth;
    d.mode  = MD_NONE;
    d.rd    = c[0];
    d.start = '0;
    if (cv < 2) begin
      d.mode = MD_CLK_BURST;
    end else if (cv < 2 + 2 * nreg) begin
      d.mode  = MD_REG_ONE;
      d.start = 8'((cv - 2) >> 1);
    end else if (cv >= rb && cv < ram_end) begin
      d.mode  = MD_RAM_ONE;
      d.start = 8'((cv - rb) >> 1);
    end else if (cv == ram_end || cv == ram_end + 1) begin
      d.mode = MD_RAM_BURST;
    end
    return d;
  endfunction

endpackage

// File: rtl/rtc_addr_seq.sv
module rtc_addr_seq #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] load_last,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          done
);

  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      last_q <= '0;
      done   <= 1'b1;
    end else if (load) begin
      addr   <= load_addr;
      last_q <= load_last;
      done   <= 1'b0;
    end else if (step && !done) begin
      if (addr == last_q) done <= 1'b1;
      else                addr <= addr + 1'b1;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !done && addr == last_q) |=> (done && addr == $past(addr))); // R5

endmodule

// File: rtl/rtc_clk_stage.sv
module rtc_clk_stage #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RW-1:0]      idx,
  input  logic [DW-1:0]      din,
  output logic [NREG*DW-1:0] dout
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                        dout[g*DW +: DW] <= '0;
      else if (wr_en && idx == RW'(g))   dout[g*DW +: DW] <= din;
    end
  end

endmodule

// File: rtl/rtc_cmd_seq.sv
module rtc_cmd_seq
  import rtc_cmd_pkg::*;
#(
  parameter logic [7:0] RAM_BASE  = 8'h3E,
  parameter int         RAM_DEPTH = 96,
  parameter int         NREG      = 8,
  parameter int         DW        = 8,
  localparam int        AW        = $clog2(RAM_DEPTH),
  localparam int        RW        = $clog2(NREG),
  localparam int        CTRL_IDX  = NREG - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_byte,
  input  logic               byte_valid,
  input  logic [DW-1:0]      byte_data,
  input  logic               rd_req,
  input  logic               stop,
  input  logic               ctl_wp,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  output logic               ram_we,
  output logic               ram_re,
  output logic [RW-1:0]      reg_idx,
  output logic [DW-1:0]      reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  output logic               burst_load,
  output logic [NREG*DW-1:0] burst_data
);

  cmd_t  dec;
  mode_e mode_q;
  logic  rd_q, wp_lat_q;

  logic [AW-1:0] seq_addr, load_addr, load_last;
  logic          seq_done;

  // Named events for the assertions.
  logic xfer_ev, wr_ev, rd_ev, stop_ev;
  logic is_ram, is_reg, is_clk;
  logic ram_wr_go, ram_rd_go, reg_wr_go, reg_rd_go;
  logic stage_wr, stage_full, commit_go;

  assign dec = decode_cmd(cmd_byte, RAM_BASE, RAM_DEPTH, NREG);

  always_comb begin
    case (dec.mode)
      MD_RAM_BURST: begin load_addr = '0; load_last = AW'(RAM_DEPTH - 1); end
      MD_CLK_BURST: begin load_addr = '0; load_last = AW'(NREG - 1);      end
      default:      begin load_addr = AW'(dec.start); load_last = AW'(dec.start); end
    endcase
  end

  assign is_ram = (mode_q == MD_RAM_ONE) || (mode_q == MD_RAM_BURST);
  assign is_reg = (mode_q == MD_REG_ONE);
  assign is_clk = (mode_q == MD_CLK_BURST);

  assign xfer_ev = !cmd_valid && (mode_q != MD_NONE) && !seq_done &&
                   (rd_q ? rd_req : byte_valid);
  assign wr_ev   = xfer_ev && !rd_q;
  assign rd_ev   = xfer_ev && rd_q;
  assign stop_ev = stop && !cmd_valid;

  assign ram_wr_go  = wr_ev && is_ram && !ctl_wp;
  assign ram_rd_go  = rd_ev && is_ram;
  assign reg_wr_go  = wr_ev && is_reg && (!ctl_wp || seq_addr == AW'(CTRL_IDX));
  assign reg_rd_go  = rd_ev && (is_reg || is_clk);
  assign stage_wr   = wr_ev && is_clk;
  assign stage_full = seq_done || (stage_wr && seq_addr == AW'(NREG - 1));
  assign commit_go  = stop_ev && is_clk && !rd_q && stage_full && !wp_lat_q;

  rtc_addr_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_valid),
    .load_addr (load_addr),
    .load_last (load_last),
    .step      (xfer_ev),
    .addr      (seq_addr),
    .done      (seq_done)
  );

  rtc_clk_stage #(.NREG(NREG), .DW(DW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (stage_wr),
    .idx   (seq_addr[RW-1:0]),
    .din   (byte_data),
    .dout  (burst_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MD_NONE;
      rd_q     <= 1'b0;
      wp_lat_q <= 1'b0;
    end else if (cmd_valid) begin
      mode_q   <= dec.mode;
      rd_q     <= dec.rd;
      wp_lat_q <= ctl_wp;
    end else if (stop_ev) begin
      mode_q   <= MD_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we     <= 1'b0;
      ram_re     <= 1'b0;
      reg_we     <= 1'b0;
      reg_re     <= 1'b0;
      burst_load <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
    end else begin
      ram_we     <= ram_wr_go;
      ram_re     <= ram_rd_go;
      reg_we     <= reg_wr_go;
      reg_re     <= reg_rd_go;
      burst_load <= commit_go;
      if (ram_wr_go || ram_rd_go) ram_addr  <= seq_addr;
      if (ram_wr_go)              ram_wdata <= byte_data;
      if (reg_wr_go || reg_rd_go) reg_idx   <= seq_addr[RW-1:0];
      if (reg_wr_go)              reg_wdata <= byte_data;
    end
  end

  AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (ram_addr < AW'(RAM_DEPTH))); // R1
  AST_RAM_WP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !$past(ctl_wp)); // R6
  AST_REG_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx != RW'(CTRL_IDX)) |-> !$past(ctl_wp)); // R7
  AST_LOAD_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_load |-> $past(stop)); // R8
  AST_LOAD_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_load |-> !$past(wp_lat_q)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NONE) |=> !(ram_we || ram_re || reg_we || reg_re)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ram_re, reg_we, reg_re, burst_load})); // R11

endmodule

// File: tb/rtc_cmd_seq_bench.sv
module rtc_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        rd_req = 1'b0;
  logic        stop = 1'b0;
  logic        ctl_wp = 1'b0;
  logic [6:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we, ram_re;
  logic [2:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic        reg_we, reg_re, burst_load;
  logic [63:0] burst_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rtc_cmd_seq u_rtc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
    .stop(stop), .ctl_wp(ctl_wp), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_re(ram_re), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .burst_load(burst_load),
    .burst_data(burst_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Each driver holds its strobe for one rising edge; outputs are read at the next falling edge.
  task automatic send_cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_byte = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask
  task automatic send_rd();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask
  task automatic send_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic t_reset();
    check({ram_we, ram_re, reg_we, reg_re, burst_load} == 5'b0, "R12 strobes after reset",
          {ram_we, ram_re, reg_we, reg_re, burst_load}, 0);
  endtask

  task automatic t_ram_single();
    send_cmd(8'h48);                     // location 5
    send_byte(8'hA5);
    check(ram_we && ram_addr == 7'd5 && ram_wdata == 8'hA5, "R1 single ram write",
          {ram_we, ram_addr, ram_wdata}, {1'b1, 7'd5, 8'hA5});
    send_byte(8'h11);
    check(!ram_we, "R1 second byte ignored", ram_we, 0);
    send_stop();
    send_cmd(8'hFD);                     // location 95
    send_rd();
    check(ram_re && ram_addr == 7'd95, "R1 single ram read top", {ram_re, ram_addr},
          {1'b1, 7'd95});
    send_stop();
  endtask

  task automatic t_ram_burst_write();
    int bad = 0;
    send_cmd(8'hFE);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'h30 + i));
      if (!(ram_we && ram_addr == 7'(i) && ram_wdata == 8'(8'h30 + i))) bad++;
    end
    check(bad == 0, "R2 R3 burst write each byte at once", bad, 0);
    send_stop();
    check(!ram_we, "R3 early stop no extra write", ram_we, 0);
  endtask

  task automatic t_ram_burst_full();
    int bad = 0;
    send_cmd(8'hFE);
    for (int i = 0; i < 96; i++) begin
      send_byte(8'(i));
      if (!(ram_we && ram_addr == 7'(i))) bad++;
    end
    check(bad == 0, "R2 burst write 96 locations", bad, 0);
    send_byte(8'hEE);
    check(!ram_we, "R5 97th byte no wrap", {ram_we, ram_addr}, 0);
    send_stop();
  endtask

  task automatic t_ram_burst_read();
    int bad = 0;
    send_cmd(8'hFF);
    for (int i = 0; i < 96; i++) begin
      send_rd();
      if (!(ram_re && ram_addr == 7'(i))) bad++;
    end
    check(bad == 0, "R4 burst read 0..95", bad, 0);
    send_rd();
    check(!ram_re, "R4 read past 95", ram_re, 0);
    send_stop();
  endtask

  task automatic t_protect();
    ctl_wp = 1'b1;
    send_cmd(8'h40);
    send_byte(8'h77);
    check(!ram_we, "R6 protected ram write", ram_we, 0);
    send_stop();
    send_cmd(8'hFE);
    send_byte(8'h01);
    check(!ram_we, "R6 protected ram burst", ram_we, 0);
    send_stop();
    send_cmd(8'h06);                     // register 2
    send_byte(8'h12);
    check(!reg_we, "R7 protected timekeeping write", reg_we, 0);
    send_stop();
    send_cmd(8'h10);                     // control register
    send_byte(8'h80);
    check(reg_we && reg_idx == 3'd7 && reg_wdata == 8'h80, "R7 control write under protect",
          {reg_we, reg_idx, reg_wdata}, {1'b1, 3'd7, 8'h80});
    send_stop();
    ctl_wp = 1'b0;
    send_cmd(8'h06);
    send_byte(8'h34);
    check(reg_we && reg_idx == 3'd2 && reg_wdata == 8'h34, "R7 register write",
          {reg_we, reg_idx, reg_wdata}, {1'b1, 3'd2, 8'h34});
    send_stop();
    send_cmd(8'h0B);                     // read register 4
    send_rd();
    check(reg_re && reg_idx == 3'd4, "R7 register read", {reg_re, reg_idx}, {1'b1, 3'd4});
    send_stop();
  endtask

  task automatic t_clk_burst(input int nbytes, input bit wp_at_cmd, input bit join_stop,
                             input bit exp_load, input string tag);
    logic [63:0] exp_data = '0;
    int early = 0;
    ctl_wp = wp_at_cmd;
    send_cmd(8'h00);
    ctl_wp = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      exp_data[i*8 +: 8] = 8'(8'hC0 + i);
      if (join_stop && i == nbytes - 1) stop = 1'b1;
      send_byte(8'(8'hC0 + i));
      stop = 1'b0;
      if ((burst_load && !(join_stop && i == nbytes - 1)) || reg_we) early++;
    end
    if (!join_stop) send_stop();
    check(early == 0, {tag, " no strobe before stop"}, early, 0);
    check(burst_load == exp_load, {tag, " load"}, burst_load, exp_load);
    if (exp_load)
      check(burst_data == exp_data, {tag, " data"}, burst_data, exp_data);
  endtask

  task automatic t_clk_burst_read();
    int bad = 0;
    send_cmd(8'h01);
    for (int i = 0; i < 8; i++) begin
      send_rd();
      if (!(reg_re && reg_idx == 3'(i))) bad++;
    end
    check(bad == 0, "R8 clock burst read 0..7", bad, 0);
    send_rd();
    check(!reg_re, "R8 clock burst read ends", reg_re, 0);
    send_stop();
  endtask

  task automatic t_undefined();
    logic [4:0] seen;
    send_cmd(8'h20);
    send_byte(8'h55);
    seen = {ram_we, ram_re, reg_we, reg_re, burst_load};
    send_rd();
    seen |= {ram_we, ram_re, reg_we, reg_re, burst_load};
    send_stop();
    seen |= {ram_we, ram_re, reg_we, reg_re, burst_load};
    check(seen == 5'b0, "R10 undefined command ignored", seen, 0);
  endtask

  task automatic t_cmd_collision();
    send_cmd(8'hFE);
    byte_valid = 1'b1; byte_data = 8'h99;   // byte together with a new command
    send_cmd(8'h44);                     // location 3
    byte_valid = 1'b0;
    check(!ram_we, "R11 byte in command cycle ignored", ram_we, 0);
    send_byte(8'h66);
    check(ram_we && ram_addr == 7'd3 && ram_wdata == 8'h66, "R11 next byte uses new command",
          {ram_we, ram_addr, ram_wdata}, {1'b1, 7'd3, 8'h66});
    send_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_single();
    t_ram_burst_write();
    t_ram_burst_full();
    t_ram_burst_read();
    t_protect();
    t_clk_burst(8, 1'b0, 1'b0, 1'b1, "R8 clock burst write");
    t_clk_burst(7, 1'b0, 1'b0, 1'b0, "R9 short clock burst");
    t_clk_burst(8, 1'b1, 1'b0, 1'b0, "R9 protected clock burst");
    t_clk_burst(8, 1'b0, 1'b1, 1'b1, "R11 last byte with stop");
    t_clk_burst_read();
    t_undefined();
    t_cmd_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired R12 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule